// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes serial audio from an external source as a bit clock, a word clock and three data pins, and turns it into six parallel 24-bit two's-complement sample words. A faster system clock oversamples BCLK and LRCLK. A single bit-slot engine counts bit periods from each word-clock event and decides which bit periods carry sample bits. A 3-bit format code and a 2-bit length code choose the layout. Four layouts are two-channel formats that use all three data pins: I2S, left-justified, right-justified and DSP frame-sync. Two layouts are six-channel packed formats that use data pin 0 only.

Words are gathered per channel. Each completed stereo pair, or each completed six-channel frame, is presented on a valid/ready output stage that holds all six channels.

Back-pressure rules:
- The output is held stable while `m_valid` is high and `m_ready` is low.
- The serial source cannot be stalled. If a newer frame completes before the held one is accepted, the newer frame replaces it and `m_valid` stays high.

Channel numbering for the two-channel formats: data pin k feeds channel 2k (left) and channel 2k+1 (right). In the packed formats, slot k of the left half feeds channel 2k and slot k of the right half feeds channel 2k+1. Channel c occupies `m_data[24c+23:24c]`.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset `m_valid` is low and `m_data` is all zeros.
- R2: Length code 00 selects 24 bits, 01 selects 20 bits, 10 selects 16 bits, and the reserved code 11 is taken as 24 bits. A word shorter than 24 bits is placed with its MSB at bit 23 of its channel field, and the unused low bits are zero.
- R3: Format code 000 (I2S): LRCLK low marks left. Bits are taken on BCLK rising edges. The MSB arrives one bit period after each LRCLK change, and each sample period lasts 64 bit periods.
- R4: Format code 011 (left-justified): LRCLK high marks left. The MSB arrives in the first bit period after each LRCLK change, and bits are taken on rising edges.
- R5: Format code 001 (right-justified): LRCLK high marks left. The LSB is in the last of the 32 bit periods of each half, so the MSB arrives 32 minus the word length bit periods after the change.
- R6: Format code 010 (DSP): a rising frame sync starts each word, and bits are taken on BCLK falling edges. The MSB comes one bit period after the frame sync is first seen high. After lock, the words alternate left, then right, starting with left.
- R7: Format code 100 (packed, 256 bit periods per sample, pin 0 only): each half holds four 32-period slots. Slots 0 to 2 carry data, and the fourth slot is empty. The MSB arrives one period after the slot starts. LRCLK low marks the left half.
- R8: Format code 101 (packed, 128 bit periods per sample, pin 0 only): each half holds three 20-period slots followed by a 4-period gap. The MSB arrives in the first period of the slot. LRCLK high marks left. Words are capped at 20 bits whatever the length code says.
- R9: Format codes 110 and 111 produce no output frames.
- R10: A completed pair or frame raises `m_valid`. `m_valid` and `m_data` hold until a cycle with `m_ready` high, after which `m_valid` falls.
- R11: Until the first frame completes after reset, the format and length codes are followed directly. After that, a change on the code inputs takes effect only when the next frame completes, so the frame in progress still decodes under the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Word clock or frame sync |
| sdin | input | PINS (3) | Serial data pins |
| fmt_mode | input | 3 | Format code |
| wlen_code | input | 2 | Word-length code |
| m_valid | output | 1 | Output frame valid |
| m_ready | input | 1 | Output frame accepted |
| m_data | output | 2*PINS*SW (144) | Six channel words, channel c at bits 24c+23:24c |

## Verification
The bench keeps the default parameters: three data pins, 24-bit sample fields and two synchroniser stages. With three pins, every pin-to-channel route and all three packed slots per half can be seen at the output. A 24-bit field lets every length code, including the cap to 20 bits in the 128-period packed format, be checked for left alignment.

The bench sweeps all six data formats against all three valid length codes. For each pairing it computes the expected channel words arithmetically, including the most negative, most positive, minus-one and zero values. It also covers the silent codes and a format change partway through a stream.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef enum logic [2:0] {
    FMT_I2S  = 3'b000,
    FMT_RJ   = 3'b001,
    FMT_DSP  = 3'b010,
    FMT_LJ   = 3'b011,
    FMT_P256 = 3'b100,
    FMT_P128 = 3'b101,
    FMT_AUX  = 3'b110,
    FMT_RSV  = 3'b111
  } fmt_e;

  // Effective word length in bits; the 128-period packed layout caps at 20.
  function automatic logic [4:0] word_bits(input fmt_e fmt, input logic [1:0] wl);
    logic [4:0] w;
    case (wl)
      2'b01:   w = 5'd20;
      2'b10:   w = 5'd16;
      default: w = 5'd24;
    endcase
    if (fmt == FMT_P128 && w > 5'd20) w = 5'd20;
    return w;
  endfunction

  // Bit-period index, counted from the word or slot start, that carries the MSB.
  function automatic logic [5:0] first_bit(input fmt_e fmt, input logic [4:0] w);
    case (fmt)
      FMT_I2S, FMT_DSP, FMT_P256: return 6'd1;
      FMT_RJ:                     return 6'd32 - {1'b0, w};
      default:                    return 6'd0;
    endcase
  endfunction

  function automatic logic is_packed(input fmt_e fmt);
    return (fmt == FMT_P256) || (fmt == FMT_P128);
  endfunction

  function automatic logic [5:0] slot_len(input fmt_e fmt);
    case (fmt)
      FMT_P256: return 6'd32;
      FMT_P128: return 6'd20;
      default:  return 6'd63;
    endcase
  endfunction

  // LRCLK level that marks the left half.
  function automatic logic left_level(input fmt_e fmt);
    return !((fmt == FMT_I2S) || (fmt == FMT_P256));
  endfunction

  function automatic logic fmt_silent(input fmt_e fmt);
    return (fmt == FMT_AUX) || (fmt == FMT_RSV);
  endfunction
endpackage

// File: rtl/sarx_sync_edge.sv
module sarx_sync_edge #(
  parameter int PINS   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk,
  input  logic            lrclk,
  input  logic [PINS-1:0] sdin,
  input  logic            use_fall,
  output logic            smp_en,
  output logic            lr_smp,
  output logic [PINS-1:0] sd_smp
);
  localparam int W = PINS + 2;

  logic [W-1:0] pipe [STAGES];
  logic         bclk_d;
  logic         b_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      bclk_d <= 1'b0;
    end else begin
      pipe[0] <= {bclk, lrclk, sdin};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      bclk_d <= pipe[STAGES-1][W-1];
    end
  end

  assign b_now  = pipe[STAGES-1][W-1];
  assign smp_en = use_fall ? (!b_now && bclk_d) : (b_now && !bclk_d);
  assign lr_smp = pipe[STAGES-1][W-2];
  assign sd_smp = pipe[STAGES-1][PINS-1:0];
endmodule

// File: rtl/sarx_slot_ctrl.sv
module sarx_slot_ctrl
  import sarx_pkg::*;
#(
  parameter int PINS = 3,
  parameter int SLW  = $clog2(PINS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  fmt_e           fmt,
  input  logic [1:0]     wl,
  input  logic           smp_en,
  input  logic           lr,
  output logic           cap_en,
  output logic           word_last,
  output logic           side,
  output logic [SLW-1:0] slot,
  output logic           frame_done
);
  logic [5:0]     bit_q, cur_bit, nxt_bit;
  logic [SLW-1:0] slot_q, cur_slot, nxt_slot;
  logic           side_q, lr_q, locked_q;
  logic           dsp, packed_m, start, in_word;
  logic [4:0]     w;
  logic [6:0]     off, end_b;

  assign dsp      = (fmt == FMT_DSP);
  assign packed_m = is_packed(fmt);
  assign w        = word_bits(fmt, wl);
  assign off      = {1'b0, first_bit(fmt, w)};
  assign end_b    = off + {2'b0, w};
  assign start    = dsp ? (lr && !lr_q) : (lr != lr_q);

  always_comb begin
    cur_bit  = start ? '0 : bit_q;
    cur_slot = start ? '0 : slot_q;
    nxt_bit  = cur_bit;
    nxt_slot = cur_slot;
    if (packed_m && ({1'b0, cur_bit} + 7'd1 == {1'b0, slot_len(fmt)})) begin
      nxt_bit = '0;
      if (cur_slot != '1) nxt_slot = cur_slot + 1'b1;
    end else if (cur_bit != '1) begin
      nxt_bit = cur_bit + 6'd1;
    end
  end

  assign side    = dsp ? side_q : (lr != left_level(fmt));
  assign slot    = cur_slot;
  assign in_word = (locked_q || start) && !fmt_silent(fmt)
                   && (int'(cur_slot) < PINS)
                   && ({1'b0, cur_bit} >= off) && ({1'b0, cur_bit} < end_b);
  assign cap_en     = smp_en && in_word;
  assign word_last  = cap_en && ({1'b0, cur_bit} == end_b - 7'd1);
  assign frame_done = word_last && side
                      && (!packed_m || int'(cur_slot) == PINS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q    <= '0;
      slot_q   <= '0;
      side_q   <= 1'b0;
      lr_q     <= 1'b0;
      locked_q <= 1'b0;
    end else if (smp_en) begin
      lr_q   <= lr;
      bit_q  <= nxt_bit;
      slot_q <= nxt_slot;
      if (start) locked_q <= 1'b1;
      if (!dsp)                      side_q <= 1'b0;
      else if (start && !locked_q)   side_q <= 1'b0;
      else if (word_last)            side_q <= ~side_q;
    end
  end

  // R6: a DSP word that ends on the left never closes a frame
  AST_DSP_LEFT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp && word_last && !side_q) |-> !frame_done); // R6
endmodule

// File: rtl/sarx_assemble.sv
module sarx_assemble
  import sarx_pkg::*;
#(
  parameter int PINS = 3,
  parameter int SW   = 24,
  parameter int SLW  = $clog2(PINS + 1),
  localparam int NCH = 2 * PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  fmt_e            fmt,
  input  logic [1:0]      wl,
  input  logic            cap_en,
  input  logic            word_last,
  input  logic            side,
  input  logic [SLW-1:0]  slot,
  input  logic [PINS-1:0] sd,
  output logic [NCH*SW-1:0] ch_next
);
  logic [SW-1:0] sh_q    [PINS];
  logic [SW-1:0] sh_nx   [PINS];
  logic [SW-1:0] aligned [PINS];
  logic [SW-1:0] ch_q    [NCH];
  logic [SW-1:0] ch_d    [NCH];
  logic [4:0]    sh_amt;

  assign sh_amt = 5'(SW) - word_bits(fmt, wl);

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    assign sh_nx[p]   = {sh_q[p][SW-2:0], sd[p]};
    assign aligned[p] = sh_nx[p] << sh_amt;
    always_ff @(posedge clk) begin
      if (!rst_n)      sh_q[p] <= '0;
      else if (cap_en) sh_q[p] <= sh_nx[p];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      ch_d[c] = ch_q[c];
      if (word_last) begin
        if (is_packed(fmt)) begin
          if (int'(slot) * 2 + int'(side) == c) ch_d[c] = aligned[0];
        end else if (int'(side) == c % 2) begin
          ch_d[c] = aligned[c / 2];
        end
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) ch_q[c] <= '0;
      else        ch_q[c] <= ch_d[c];
    end
    assign ch_next[c*SW +: SW] = ch_d[c];
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int PINS        = 3,
  parameter int SW          = 24,
  parameter int SYNC_STAGES = 2,
  localparam int NCH = 2 * PINS,
  localparam int SLW = $clog2(PINS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              lrclk,
  input  logic [PINS-1:0]   sdin,
  input  logic [2:0]        fmt_mode,
  input  logic [1:0]        wlen_code,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [NCH*SW-1:0] m_data
);
  fmt_e            cfg_fmt_q;
  logic [1:0]      cfg_wl_q;
  logic            have_frame_q, load_cfg;
  logic            smp_en, lr_smp, cap_en, word_last, side, frame_done;
  logic [PINS-1:0] sd_smp;
  logic [SLW-1:0]  slot;
  logic [NCH*SW-1:0] ch_next;
  logic [4:0]      out_w_q;

  sarx_sync_edge #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdin(sdin),
    .use_fall(cfg_fmt_q == FMT_DSP), .smp_en(smp_en), .lr_smp(lr_smp), .sd_smp(sd_smp)
  );

  sarx_slot_ctrl #(.PINS(PINS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fmt(cfg_fmt_q), .wl(cfg_wl_q), .smp_en(smp_en),
    .lr(lr_smp), .cap_en(cap_en), .word_last(word_last), .side(side),
    .slot(slot), .frame_done(frame_done)
  );

  sarx_assemble #(.PINS(PINS), .SW(SW)) u_asm (
    .clk(clk), .rst_n(rst_n), .fmt(cfg_fmt_q), .wl(cfg_wl_q), .cap_en(cap_en),
    .word_last(word_last), .side(side), .slot(slot), .sd(sd_smp), .ch_next(ch_next)
  );

  assign load_cfg = !have_frame_q || frame_done || fmt_silent(cfg_fmt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_fmt_q    <= FMT_I2S;
      cfg_wl_q     <= 2'b00;
      have_frame_q <= 1'b0;
      m_valid      <= 1'b0;
      m_data       <= '0;
      out_w_q      <= 5'd24;
    end else begin
      if (load_cfg) begin
        cfg_fmt_q <= fmt_e'(fmt_mode);
        cfg_wl_q  <= wlen_code;
      end
      if (frame_done) begin
        have_frame_q <= 1'b1;
        m_valid      <= 1'b1;
        m_data       <= ch_next;
        out_w_q      <= word_bits(cfg_fmt_q, cfg_wl_q);
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid); // R10
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !frame_done) |=> $stable(m_data)); // R10
  AST_FRAME_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> m_valid); // R10
  AST_SILENT_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_silent(cfg_fmt_q) |-> !frame_done); // R9
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && out_w_q == 5'd16) |-> (m_data[c*SW +: SW-16] == '0)); // R2
  end
endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  localparam int PINS = 3;
  localparam int SW   = 24;
  localparam int DW   = 2 * PINS * SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, lrclk = 1'b0, m_ready = 1'b0;
  logic [PINS-1:0] sdin = '0;
  logic [2:0] fmt_mode = 3'b000;
  logic [1:0] wlen_code = 2'b00;
  logic m_valid;
  logic [DW-1:0] m_data;
  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdin(sdin),
    .fmt_mode(fmt_mode), .wlen_code(wlen_code), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data)
  );

  function automatic int unsigned samp(int f, int c, int w);
    int unsigned mask;
    int unsigned v;
    mask = (32'd1 << w) - 1;
    if (f == 1) begin
      case (c)
        0: v = 32'd1 << (w - 1);
        1: v = mask >> 1;
        2: v = mask;
        3: v = 0;
        4: v = 1;
        default: v = 32'h00A5A5A5;
      endcase
    end else begin
      v = f * 40503 + c * 9301 + 12345;
      v = v ^ (v << 7) ^ (v >> 3);
    end
    return v & mask;
  endfunction

  function automatic logic sbit(int f, int c, int w, int k);
    return logic'((samp(f, c, w) >> (w - 1 - k)) & 1);
  endfunction

  function automatic logic [3:0] tick_val(int m, int w, int f, int t);
    logic lr;
    logic [2:0] sd;
    int side, pos, off, slot, b;
    sd = '0;
    lr = 1'b0;
    case (m)
      0, 1, 2, 3: begin
        side = (t >= 32) ? 1 : 0;
        pos  = t % 32;
        off  = (m == 0 || m == 2) ? 1 : (m == 1) ? 32 - w : 0;
        if (m == 0)      lr = (t >= 32);
        else if (m == 2) lr = (pos == 0);
        else             lr = (t < 32);
        if (pos >= off && pos < off + w)
          for (int p = 0; p < PINS; p++) sd[p] = sbit(f, 2 * p + side, w, pos - off);
      end
      4: begin
        side = (t >= 128) ? 1 : 0;
        lr   = (t >= 128);
        pos  = t % 128;
        slot = pos / 32;
        b    = pos % 32;
        if (slot < 3 && b >= 1 && b <= w) sd[0] = sbit(f, 2 * slot + side, w, b - 1);
      end
      default: begin
        side = (t >= 64) ? 1 : 0;
        lr   = (t < 64);
        pos  = t % 64;
        slot = pos / 20;
        b    = pos % 20;
        if (slot < 3 && b < w) sd[0] = sbit(f, 2 * slot + side, w, b);
      end
    endcase
    return {lr, sd};
  endfunction

  task automatic play_frame(int m, int w, int f);
    int len;
    logic [3:0] v;
    len = (m == 4) ? 256 : (m == 5) ? 128 : 64;
    for (int t = 0; t < len; t++) begin
      v = tick_val(m, w, f, t);
      @(negedge clk);
      if (m == 2) begin
        bclk = 1'b1; lrclk = v[3]; sdin = v[2:0];
        repeat (4) @(negedge clk);
        bclk = 1'b0;
        repeat (3) @(negedge clk);
      end else begin
        lrclk = v[3]; sdin = v[2:0];
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
      end
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: m_valid actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_data(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: m_data actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ready();
    @(negedge clk) m_ready = 1'b1;
    @(negedge clk) m_ready = 1'b0;
  endtask

  task automatic do_reset(int m, int wl);
    @(negedge clk);
    rst_n = 1'b0; fmt_mode = 3'(m); wlen_code = 2'(wl);
    bclk = 1'b0; lrclk = 1'b0; sdin = '0; m_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] expect_frame(int w, int f);
    logic [DW-1:0] e;
    for (int c = 0; c < 2 * PINS; c++) e[c*SW +: SW] = SW'(samp(f, c, w) << (SW - w));
    return e;
  endfunction

  task automatic check_frame(string req, int w, int f);
    chk_bit(req, m_valid, 1'b1);
    chk_data(req, m_data, expect_frame(w, f));
    repeat (10) @(negedge clk);
    chk_bit("R10 hold", m_valid, 1'b1);
    chk_data("R10 stable", m_data, expect_frame(w, f));
    pulse_ready();
    chk_bit("R10 accept", m_valid, 1'b0);
  endtask

  function automatic string mode_req(int m);
    case (m)
      0: return "R3 I2S (R2 length)";
      1: return "R5 right-justified (R2 length)";
      2: return "R6 DSP (R2 length)";
      3: return "R4 left-justified (R2 length)";
      4: return "R7 packed256 (R2 length)";
      default: return "R8 packed128 (R2 length)";
    endcase
  endfunction

  initial begin
    do_reset(0, 0);
    chk_bit("R1 reset valid", m_valid, 1'b0);
    chk_data("R1 reset data", m_data, '0);

    for (int m = 0; m < 6; m++) begin
      for (int wl = 0; wl < 3; wl++) begin
        int w;
        w = (wl == 0) ? 24 : (wl == 1) ? 20 : 16;
        if (m == 5 && w > 20) w = 20;
        do_reset(m, wl);
        play_frame(m, w, 0);
        pulse_ready();
        for (int f = 1; f <= 3; f++) begin
          play_frame(m, w, f);
          check_frame(mode_req(m), w, f);
        end
      end
    end

    // R2: reserved length code is taken as 24 bits
    do_reset(3, 3);
    play_frame(3, 24, 0);
    pulse_ready();
    play_frame(3, 24, 1);
    check_frame("R2 reserved length", 24, 1);

    // R9: silent codes
    for (int m = 6; m < 8; m++) begin
      do_reset(m, 0);
      for (int f = 0; f < 3; f++) play_frame(0, 24, f);
      chk_bit("R9 silent code", m_valid, 1'b0);
    end

    // R11: change applies only at the next frame boundary
    do_reset(0, 0);
    play_frame(0, 24, 0);
    pulse_ready();
    play_frame(0, 24, 1);
    check_frame("R11 before change", 24, 1);
    fmt_mode = 3'b011;
    play_frame(0, 24, 2);
    check_frame("R11 old format kept", 24, 2);
    play_frame(3, 24, 3);
    pulse_ready();
    play_frame(3, 24, 4);
    check_frame("R11 new format", 24, 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule